// File: doc/BRIEF.md
# Clock-Group Phase Enable Generator

This block replaces a set of synchronous clocks, each with its own period and phase offset, by one base clock and a set of per-domain enable strobes. The periods and offsets are elaboration-time parameters. They are given in one common time unit, with offsets measured from the group's reference edge. At elaboration the block derives the base tick. This is the greatest common divisor of every period and every nonzero offset. Each period and offset is then rescaled into base ticks, and the wrap length of a shared phase counter is computed as the least common multiple of the rescaled values.

On every base cycle where a domain's original clock would have had an active edge, that domain's raw phase strobe is high. A flip-flop converted to the base clock loads only when three conditions hold together: its domain's phase strobe, a gated-clock enable that stands in for a clock gate, and the flip-flop's own functional enable. The raw strobes and the phase count are also brought out as test outputs, so the schedule can be checked on its own, apart from the gating. Clocks belonging to other, asynchronous groups are not handled here.

Top module: `clkgrp_enable_gen`

## Requirements
- R1: The base tick is the greatest common divisor of all domain periods and nonzero offsets. A domain's strobe recurs every period/base base cycles. With the defaults (periods 8, 12, 24 and offsets 0, 4, 6, giving base 2), the spacings are 4, 6 and 12 cycles.
- R2: `phase_cnt` increments by one per base cycle and returns to 0 after reaching WRAP-1. WRAP is the least common multiple of the rescaled periods and the nonzero rescaled offsets (12 with the defaults).
- R3: `load_en[i]` is high exactly when `gate_en[i]`, `func_en[i]` and `phase_strobe[i]` are all high. Bit i of each vector belongs to domain i.
- R4: `phase_strobe[i]` is high exactly on cycles where (phase_cnt − offset_i) mod period_i = 0, in base ticks. With the defaults, domain 0 fires at counts 0, 4 and 8, domain 1 at counts 2 and 8, and domain 2 at count 3.
- R5: While `rst_n` is low, `phase_cnt` is 0 and all strobes and load enables are low. The first clock edge with `rst_n` high starts the count-0 base cycle, and during that cycle the strobes are live.
- R6: Domains are independent. When two domains' strobes fall on the same count, both are high in that cycle, and a low `gate_en` on one domain leaves the other domains' `load_en` unchanged.
- R7: `gate_en` and `func_en` have no effect on `phase_strobe` or `phase_cnt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock (one base tick per cycle) |
| rst_n | input | 1 | Synchronous active-low reset |
| gate_en | input | N_DOM | Per-domain gated-clock enable |
| func_en | input | N_DOM | Per-domain functional enable of the flip-flop |
| load_en | output | N_DOM | Combined per-domain load enable |
| phase_strobe | output | N_DOM | Raw per-domain phase strobe (test) |
| phase_cnt | output | CNT_W | Shared phase count, 0 to WRAP-1 |

## Verification
Two things can fall in the same base cycle. The first is strobes of different domains: with the defaults, domains 0 and 1 both fire at count 8. The second is a domain strobe coinciding with a low gate or functional enable. The bench runs the counter through many wraps, first with all enables high, then with one domain's gate held low, then with pseudo-random gate and functional patterns. In each cycle a behavioural model predicts every strobe and load enable, and at count 8 the bench confirms that both coincident strobes appear and that each load enable is masked only by its own domain's enables.

// File: rtl/clkgrp_enable_pkg.sv
// Package: integer helpers used to derive the base tick and wrap length
// at elaboration. Assumes non-negative operands; gcd(0, x) = x.
package clkgrp_enable_pkg;

    // Greatest common divisor by Euclid's method.
    function automatic int unsigned gcd_u(input int unsigned a, input int unsigned b);
        int unsigned x;
        int unsigned y;
        int unsigned t;
        x = a;
        y = b;
        while (y != 0) begin
            t = x % y;
            x = y;
            y = t;
        end
        return x;
    endfunction

    // Least common multiple; lcm(x, 0) is treated as x.
    function automatic int unsigned lcm_u(input int unsigned a, input int unsigned b);
        if (a == 0) return b;
        if (b == 0) return a;
        return (a / gcd_u(a, b)) * b;
    endfunction

endpackage

// File: rtl/cge_phase_counter.sv
// Module: shared phase counter on the base tick.
// Counts 0..WRAP-1 and wraps. A live flag is cleared by reset and set on
// the first edge after release; the count holds at 0 on that edge so the
// first live cycle is count 0. Assumes WRAP >= 1.
module cge_phase_counter #(
    parameter int unsigned WRAP  = 12,
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             live,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WRAP - 1);

    // Live flag: marks the cycles in which the schedule is valid.
    always_ff @(posedge clk) begin
        if (!rst_n) live <= 1'b0;
        else        live <= 1'b1;
    end

    // Phase count: advances only once live, wraps after LAST.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt <= '0;
        else if (live) begin
            if (cnt == LAST) cnt <= '0;
            else             cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/cge_domain_strobe.sv
// Module: one domain's phase strobe.
// Keeps its own residue of the shared count modulo PER_TICKS (valid because
// WRAP is a multiple of PER_TICKS) and fires when the residue equals the
// domain offset. Assumes PER_TICKS >= 1 and OFF_TICKS < PER_TICKS.
module cge_domain_strobe #(
    parameter int unsigned PER_TICKS = 4,
    parameter int unsigned OFF_TICKS = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic live,
    output logic strobe
);
    localparam int unsigned RW = (PER_TICKS > 1) ? $clog2(PER_TICKS) : 1;
    localparam logic [RW-1:0] RES_LAST = RW'(PER_TICKS - 1);
    localparam logic [RW-1:0] RES_HIT  = RW'(OFF_TICKS);

    logic [RW-1:0] res;

    // Residue counter: tracks the shared count modulo this domain's period.
    always_ff @(posedge clk) begin
        if (!rst_n)        res <= '0;
        else if (live) begin
            if (res == RES_LAST) res <= '0;
            else                 res <= res + 1'b1;
        end
    end

    // Strobe decode: high on this domain's active base cycles.
    always_comb strobe = live && (res == RES_HIT);
endmodule

// File: rtl/cge_enable_combine.sv
// Module: merges the three enable sources per domain.
// Pure combinational; assumes all inputs are synchronous to the base clock.
module cge_enable_combine #(
    parameter int unsigned N_DOM = 3
) (
    input  logic [N_DOM-1:0] strobe,
    input  logic [N_DOM-1:0] gate_en,
    input  logic [N_DOM-1:0] func_en,
    output logic [N_DOM-1:0] load_en
);
    // Load enable: all three sources must agree.
    always_comb load_en = strobe & gate_en & func_en;
endmodule

// File: rtl/clkgrp_enable_gen.sv
// Module: clock-group phase enable generator (top).
// Derives the base tick and wrap length from the per-domain periods and
// offsets (common time unit, packed TIME_W-bit fields, domain 0 in the low
// field), runs one shared phase counter and one strobe per domain, and
// combines each strobe with the domain's gate and functional enables.
// Assumes all clocks of the group are synchronous and every period is a
// multiple of the derived base tick (true by construction).
module clkgrp_enable_gen
    import clkgrp_enable_pkg::*;
#(
    parameter int unsigned N_DOM  = 3,
    parameter int unsigned TIME_W = 16,
    parameter logic [N_DOM*TIME_W-1:0] DOM_PERIOD = {16'd24, 16'd12, 16'd8},
    parameter logic [N_DOM*TIME_W-1:0] DOM_OFFSET = {16'd6,  16'd4,  16'd0},
    localparam int unsigned CNT_W_L = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_DOM-1:0]   gate_en,
    input  logic [N_DOM-1:0]   func_en,
    output logic [N_DOM-1:0]   load_en,
    output logic [N_DOM-1:0]   phase_strobe,
    output logic [CNT_W-1:0]   phase_cnt
);
    // Base tick: gcd of all periods and nonzero offsets.
    function automatic int unsigned calc_base();
        int unsigned g;
        g = 0;
        for (int i = 0; i < int'(N_DOM); i++) begin
            g = gcd_u(g, int'(DOM_PERIOD[i*TIME_W +: TIME_W]));
            if (DOM_OFFSET[i*TIME_W +: TIME_W] != '0)
                g = gcd_u(g, int'(DOM_OFFSET[i*TIME_W +: TIME_W]));
        end
        return (g == 0) ? 1 : g;
    endfunction

    localparam int unsigned BASE_TICK = calc_base();

    // Wrap length: lcm of rescaled periods and nonzero rescaled offsets.
    function automatic int unsigned calc_wrap();
        int unsigned l;
        l = 1;
        for (int i = 0; i < int'(N_DOM); i++) begin
            l = lcm_u(l, int'(DOM_PERIOD[i*TIME_W +: TIME_W]) / BASE_TICK);
            if (DOM_OFFSET[i*TIME_W +: TIME_W] != '0)
                l = lcm_u(l, int'(DOM_OFFSET[i*TIME_W +: TIME_W]) / BASE_TICK);
        end
        return l;
    endfunction

    localparam int unsigned WRAP_LEN = calc_wrap();
    localparam int unsigned CNT_W    = (WRAP_LEN > 1) ? $clog2(WRAP_LEN) : 1;

    logic             live;
    logic [N_DOM-1:0] strobe_w;

    cge_phase_counter #(
        .WRAP  (WRAP_LEN),
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .live  (live),
        .cnt   (phase_cnt)
    );

    for (genvar d = 0; d < N_DOM; d++) begin : g_dom
        localparam int unsigned PER_T = int'(DOM_PERIOD[d*TIME_W +: TIME_W]) / BASE_TICK;
        localparam int unsigned OFF_T = (int'(DOM_OFFSET[d*TIME_W +: TIME_W]) / BASE_TICK) % PER_T;
        cge_domain_strobe #(
            .PER_TICKS (PER_T),
            .OFF_TICKS (OFF_T)
        ) u_strobe (
            .clk    (clk),
            .rst_n  (rst_n),
            .live   (live),
            .strobe (strobe_w[d])
        );
    end

    cge_enable_combine #(
        .N_DOM (N_DOM)
    ) u_comb (
        .strobe  (strobe_w),
        .gate_en (gate_en),
        .func_en (func_en),
        .load_en (load_en)
    );

    // Test output: raw schedule, unmasked by any enable.
    always_comb phase_strobe = strobe_w;
endmodule

// File: rtl/clkgrp_enable_gen_chk.sv
// Module: property checker for clkgrp_enable_gen, attached by bind.
// Observes ports only; schedule checks use modulo arithmetic on the count,
// independent of the per-domain residue counters in the design.
module clkgrp_enable_gen_chk #(
    parameter int unsigned N_DOM  = 3,
    parameter int unsigned TIME_W = 16,
    parameter logic [N_DOM*TIME_W-1:0] DOM_PERIOD = '0,
    parameter logic [N_DOM*TIME_W-1:0] DOM_OFFSET = '0,
    parameter int unsigned BASE   = 1,
    parameter int unsigned WRAP   = 1,
    parameter int unsigned CNT_W  = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_DOM-1:0] gate_en,
    input logic [N_DOM-1:0] func_en,
    input logic [N_DOM-1:0] load_en,
    input logic [N_DOM-1:0] phase_strobe,
    input logic [CNT_W-1:0] phase_cnt
);
    // R2: count stays inside its range
    p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(phase_cnt) < int'(WRAP));

    // R2: count wraps to zero after its last value
    p_cnt_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(phase_cnt) == int'(WRAP) - 1) |=> (phase_cnt == '0));

    // R2: nonzero counts below the last value step by one
    p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_cnt != '0 && int'(phase_cnt) != int'(WRAP) - 1)
        |=> (int'(phase_cnt) == int'($past(phase_cnt)) + 1));

    // R3: a load never happens without its strobe or gate
    p_load_needs_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en & ~phase_strobe) == '0);
    p_load_needs_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en & ~(gate_en & func_en)) == '0);

    // R5: a cycle after reset is sampled low, the outputs are quiet
    p_reset_quiet_r5: assert property (@(posedge clk)
        !rst_n |=> (phase_cnt == '0 && phase_strobe == '0 && load_en == '0));

    // R4: each strobe lies on its domain's schedule
    for (genvar d = 0; d < N_DOM; d++) begin : g_sched
        localparam int PER_T = int'(DOM_PERIOD[d*TIME_W +: TIME_W]) / int'(BASE);
        localparam int OFF_T = (int'(DOM_OFFSET[d*TIME_W +: TIME_W]) / int'(BASE)) % PER_T;
        p_strobe_sched_r4: assert property (@(posedge clk) disable iff (!rst_n)
            phase_strobe[d] |-> (((int'(phase_cnt) + PER_T - OFF_T) % PER_T) == 0));
    end
endmodule

bind clkgrp_enable_gen clkgrp_enable_gen_chk #(
    .N_DOM      (N_DOM),
    .TIME_W     (TIME_W),
    .DOM_PERIOD (DOM_PERIOD),
    .DOM_OFFSET (DOM_OFFSET),
    .BASE       (BASE_TICK),
    .WRAP       (WRAP_LEN),
    .CNT_W      (CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .gate_en      (gate_en),
    .func_en      (func_en),
    .load_en      (load_en),
    .phase_strobe (phase_strobe),
    .phase_cnt    (phase_cnt)
);

// File: tb/clkgrp_enable_gen_tb_top.sv
// Bench: behavioural model of the default schedule (base 2, wrap 12,
// periods 4/6/12 ticks, offsets 0/2/3 ticks), compared every cycle.
module clkgrp_enable_gen_tb_top;
    localparam int ND = 3;
    localparam int MW = 12;
    localparam int PER [ND] = '{4, 6, 12};
    localparam int OFF [ND] = '{0, 2, 3};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [ND-1:0] gate_en = '0;
    logic [ND-1:0] func_en = '0;
    logic [ND-1:0] load_en;
    logic [ND-1:0] phase_strobe;
    logic [3:0]    phase_cnt;

    int n_chk = 0;
    int n_fail = 0;
    int m_cnt = 0;
    bit m_live = 0;
    int cyc = 0;
    int last_hit [ND] = '{-1, -1, -1};
    bit done = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #4 clk = ~clk;

    clkgrp_enable_gen dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .gate_en      (gate_en),
        .func_en      (func_en),
        .load_en      (load_en),
        .phase_strobe (phase_strobe),
        .phase_cnt    (phase_cnt)
    );

    // Reference model: live flag and count, advanced at each edge.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_live = 0;
            m_cnt  = 0;
        end else if (!m_live) begin
            m_live = 1;
        end else begin
            m_cnt = (m_cnt + 1) % MW;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Compares all outputs against the model for the current cycle.
    task automatic compare();
        int hits;
        bit es [ND];
        hits = 0;
        for (int d = 0; d < ND; d++) begin
            es[d] = m_live && (((m_cnt - OFF[d] + MW) % PER[d]) == 0);
            if (es[d]) hits++;
        end
        chk(int'(phase_cnt) == m_cnt, rst_n ? "R2" : "R5", int'(phase_cnt), m_cnt);
        for (int d = 0; d < ND; d++) begin
            string tag;
            bit el;
            if (!m_live)                 tag = "R5";
            else if (hits > 1)           tag = "R6";
            else if (func_en != '1 || gate_en != '1) tag = "R7";
            else                         tag = "R4";
            chk(phase_strobe[d] == es[d], tag, int'(phase_strobe[d]), int'(es[d]));
            el = es[d] && gate_en[d] && func_en[d];
            chk(load_en[d] == el, (hits > 1) ? "R6" : "R3", int'(load_en[d]), int'(el));
            if (!m_live) last_hit[d] = -1;
            else if (phase_strobe[d]) begin
                if (last_hit[d] >= 0)
                    chk(cyc - last_hit[d] == PER[d], "R1", cyc - last_hit[d], PER[d]);
                last_hit[d] = cyc;
            end
        end
    endtask

    task automatic step(input logic [ND-1:0] g, input logic [ND-1:0] f, input logic r);
        @(negedge clk);
        gate_en = g;
        func_en = f;
        rst_n   = r;
        #1;
        compare();
    endtask

    initial begin
        for (int i = 0; i < 3; i++) step('1, '1, 1'b0);
        for (int i = 0; i < 30; i++) step('1, '1, 1'b1);
        for (int i = 0; i < 30; i++) step(3'b101, '1, 1'b1);
        for (int i = 0; i < 60; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[2:0], lfsr[7:5], 1'b1);
        end
        for (int i = 0; i < 3; i++) step('1, '1, 1'b0);
        for (int i = 0; i < 40; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[10:8], lfsr[4:2], 1'b1);
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                #100000;
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: actual 0 expected 1 (run incomplete)");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule